// File: doc/BRIEF.md
# Record-then-Playback Audio Sequencer

This block runs a single capture-and-replay cycle of audio. While idle it waits for a start press. On that press it moves to the recording phase and takes a fixed number of samples from a sample-valid stream. It writes each sample to the next word address of an external memory through a request/acknowledge port. No sample is kept on chip beyond a single read buffer. The write for the last sample moves the block straight into playback. Playback reads the words back from address zero upward and sends one sample to an audio output stream on every sample-rate tick.

A 16-LED bar shows progress. During recording it fills from the leftmost LED (bit 15) toward the right. During playback it empties from the rightmost lit LED back toward the left. The sample count is a parameter, for example 240000 for five seconds at 48 kHz.

The states and transitions are as follows. `ST_IDLE` goes to `ST_RECORD` on a start press. `ST_RECORD` goes to `ST_PLAYBACK` when the memory acknowledges the final write. `ST_PLAYBACK` goes to `ST_WRAPUP` when the final stored sample is emitted. `ST_WRAPUP` goes to `ST_IDLE` after one cycle.

Top module: `rec_play_seq`

## Requirements
- R1: After reset the block is in `ST_IDLE`. In that state a sample-valid pulse produces no memory request. A one-cycle `start_btn` pulse starts recording, so the next accepted sample is written to address 0.
- R2: In recording, each accepted sample drives `mem_req`=1 and `mem_we`=1 one cycle after `in_valid`. `mem_wdata` equals the sample. `mem_addr` equals the number of writes already acknowledged, running 0 to N-1.
- R3: A memory request stays asserted with unchanged address, write-enable and write data until the cycle in which `mem_ack` is sampled high. It drops in the cycle that follows.
- R4: In recording, after k acknowledged writes the top floor(k*16/N) bits of `led_bar` are 1 and all lower bits are 0.
- R5: The acknowledge of the N-th write starts playback with no user action. Playback issues reads with `mem_we`=0 at addresses 0 to N-1 in order and never issues a write.
- R6: In playback, a `tick` pulse yields a one-cycle `out_valid` in the following cycle, carrying the next stored sample in address order. After p samples have been emitted, the top floor((N-p)*16/N) bits of `led_bar` are lit. All LEDs are off once the N-th sample is emitted.
- R7: A start press during `ST_RECORD` or `ST_PLAYBACK` has no effect. Write addresses, output order and the LED bar continue unchanged.
- R8: A sample arriving while a write request is outstanding is dropped and sets `overrun_flag`. The flag stays set until a start press is accepted in `ST_IDLE`, which clears it.
- R9: If a tick arrives before the next sample has been read back, `out_valid` is pulsed with `out_data` repeating the previous output. This repeat does not count toward the N samples.
- R10: After the N-th emitted sample the block spends one `ST_WRAPUP` cycle, in which a start press is ignored, and then returns to `ST_IDLE`, where a new start is accepted.
- R11: During reset `mem_req`, `out_valid`, `overrun_flag` and `led_bar` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_btn | input | 1 | One-cycle start press |
| in_valid | input | 1 | Capture sample strobe |
| in_data | input | SAMPLE_W | Capture sample |
| tick | input | 1 | Playback sample-rate strobe |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | SAMPLE_W | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | SAMPLE_W | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Playback sample strobe |
| out_data | output | SAMPLE_W | Playback sample |
| led_bar | output | 16 | Progress bar, bit 15 leftmost |
| overrun_flag | output | 1 | Sticky dropped-sample flag |

## Verification
A wrong state or counter in this block shows at the memory port within one or two cycles. Examples are a skipped or repeated address, a write appearing during playback, or a request released before its acknowledge. The LED bar shows the same fault at the next acknowledged write or the next tick. A lost read buffer or playback counter appears on the first tick after the fault, as an out-of-order sample or a wrong repeat. The LED bar or the wrap-up timing then shows the fault at the end of the run. A mishandled overrun appears as a shifted address sequence on the next write and as a stored sample that should not be there.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RECORD   = 2'd1,
        ST_PLAYBACK = 2'd2,
        ST_WRAPUP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rps_fsm.sv
module rps_fsm
    import rps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_btn,
    input  logic       rec_done,
    input  logic       play_done,
    output seq_state_t state
);
    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_btn) state_nx = ST_RECORD;
            ST_RECORD:   if (rec_done)  state_nx = ST_PLAYBACK;
            ST_PLAYBACK: if (play_done) state_nx = ST_WRAPUP;
            ST_WRAPUP:                  state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rps_level_bar.sv
module rps_level_bar #(
    parameter int TOTAL = 240000,
    parameter int LED_N = 16,
    parameter int CNT_W = $clog2(TOTAL + 1)
) (
    input  logic [CNT_W-1:0] count,
    output logic [LED_N-1:0] bar
);
    localparam int PROD_W = CNT_W + $clog2(LED_N) + 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] level;

    always_comb begin
        prod  = PROD_W'(count) * PROD_W'(LED_N);
        level = prod / PROD_W'(TOTAL);
    end

    for (genvar k = 0; k < LED_N; k++) begin : g_seg
        assign bar[LED_N-1-k] = (level > PROD_W'(k));
    end
endmodule

// File: rtl/rec_play_seq.sv
module rec_play_seq
    import rps_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int ADDR_W      = 18,
    parameter int NUM_SAMPLES = 240000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_btn,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                tick,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [15:0]         led_bar,
    output logic                overrun_flag
);
    localparam int LED_N = 16;
    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SAMPLES - 1);
    localparam logic [CNT_W-1:0] TOTAL_C  = CNT_W'(NUM_SAMPLES);

    seq_state_t state;

    logic [CNT_W-1:0]    wr_cnt;
    logic [CNT_W-1:0]    rd_idx;
    logic [CNT_W-1:0]    play_cnt;
    logic [SAMPLE_W-1:0] rbuf;
    logic                rfull;
    logic [CNT_W-1:0]    bar_cnt;
    logic                start_ok;
    logic                rec_done;
    logic                play_done;

    assign start_ok  = start_btn && (state == ST_IDLE);
    assign rec_done  = (state == ST_RECORD) && mem_req && mem_ack && (wr_cnt == LAST_IDX);
    assign play_done = (state == ST_PLAYBACK) && tick && rfull && (play_cnt == LAST_IDX);

    rps_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_btn (start_ok),
        .rec_done  (rec_done),
        .play_done (play_done),
        .state     (state)
    );

    always_comb begin
        unique case (state)
            ST_RECORD:   bar_cnt = wr_cnt;
            ST_PLAYBACK: bar_cnt = TOTAL_C - play_cnt;
            default:     bar_cnt = '0;
        endcase
    end

    rps_level_bar #(
        .TOTAL (NUM_SAMPLES),
        .LED_N (LED_N),
        .CNT_W (CNT_W)
    ) u_bar (
        .count (bar_cnt),
        .bar   (led_bar)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req      <= 1'b0;
            mem_we       <= 1'b0;
            mem_addr     <= '0;
            mem_wdata    <= '0;
            wr_cnt       <= '0;
            rd_idx       <= '0;
            play_cnt     <= '0;
            rbuf         <= '0;
            rfull        <= 1'b0;
            out_valid    <= 1'b0;
            out_data     <= '0;
            overrun_flag <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        overrun_flag <= 1'b0;
                        wr_cnt       <= '0;
                        rd_idx       <= '0;
                        play_cnt     <= '0;
                        rfull        <= 1'b0;
                    end
                end
                ST_RECORD: begin
                    if (mem_req && mem_ack) begin
                        mem_req <= 1'b0;
                        wr_cnt  <= wr_cnt + 1'b1;
                    end
                    if (in_valid) begin
                        if (mem_req) begin
                            overrun_flag <= 1'b1;
                        end else begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_addr  <= ADDR_W'(wr_cnt);
                            mem_wdata <= in_data;
                        end
                    end
                end
                ST_PLAYBACK: begin
                    if (mem_req && mem_ack) begin
                        mem_req <= 1'b0;
                        rbuf    <= mem_rdata;
                        rfull   <= 1'b1;
                        rd_idx  <= rd_idx + 1'b1;
                    end else if (!mem_req && !rfull && (rd_idx < TOTAL_C)) begin
                        mem_req  <= 1'b1;
                        mem_we   <= 1'b0;
                        mem_addr <= ADDR_W'(rd_idx);
                    end
                    if (tick) begin
                        out_valid <= 1'b1;
                        if (rfull) begin
                            out_data <= rbuf;
                            rfull    <= 1'b0;
                            play_cnt <= play_cnt + 1'b1;
                        end
                    end
                end
                ST_WRAPUP: begin
                    mem_req <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rps_checker.sv
module rps_checker
    import rps_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_btn,
    input logic                in_valid,
    input logic                tick,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [SAMPLE_W-1:0] mem_wdata,
    input logic                mem_ack,
    input logic                out_valid,
    input logic [15:0]         led_bar,
    input logic                overrun_flag,
    input seq_state_t          state
);
    // R1: idle produces no memory traffic
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req);

    // R3: request held steady until acknowledged
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3: request released after acknowledge
    assert_req_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R4: bar is a thermometer anchored at the leftmost LED
    assert_bar_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (led_bar & ~{1'b1, led_bar[15:1]}) == 16'h0000);

    // R5: playback never writes
    assert_no_write_play_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAYBACK && mem_req) |-> !mem_we);

    // R6: output strobe follows a playback tick
    assert_out_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(tick) && $past(state) == ST_PLAYBACK));

    // R7: a start press while recording never returns to idle
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECORD && start_btn) |=> (state == ST_RECORD || state == ST_PLAYBACK));

    // R8: overrun sets on a sample during an outstanding write
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECORD && in_valid && mem_req) |=> overrun_flag);

    // R8: overrun stays set without a start press
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && !start_btn) |=> overrun_flag);

    // R10: wrap-up lasts exactly one cycle
    assert_wrapup_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAPUP) |=> (state == ST_IDLE));
endmodule

bind rec_play_seq rps_checker #(
    .SAMPLE_W (SAMPLE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_btn    (start_btn),
    .in_valid     (in_valid),
    .tick         (tick),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .out_valid    (out_valid),
    .led_bar      (led_bar),
    .overrun_flag (overrun_flag),
    .state        (state)
);

// File: tb/sim_rec_play_seq.sv
`timescale 1ns/1ps
module sim_rec_play_seq;
    localparam int SW = 16;
    localparam int AW = 16;
    localparam int N  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_btn = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic          tick = 1'b0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [SW-1:0] mem_rdata = '0;
    logic          out_valid;
    logic [SW-1:0] out_data;
    logic [15:0]   led_bar;
    logic          overrun_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [SW-1:0] mem [0:63];
    int            wr_n = 0;
    logic [AW-1:0] wr_addr [0:63];
    logic [SW-1:0] wr_data [0:63];
    logic [SW-1:0] exp2 [0:63];

    always #10 clk = ~clk;

    rec_play_seq #(.SAMPLE_W(SW), .ADDR_W(AW), .NUM_SAMPLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .in_valid(in_valid),
        .in_data(in_data), .tick(tick), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .led_bar(led_bar), .overrun_flag(overrun_flag)
    );

    // memory responder: acknowledges at the first falling edge that sees a request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[5:0]] = mem_wdata;
                    if (wr_n < 64) begin
                        wr_addr[wr_n] = mem_addr;
                        wr_data[wr_n] = mem_wdata;
                    end
                    wr_n++;
                end else begin
                    mem_rdata = mem[mem_addr[5:0]];
                end
            end
        end
    end

    function automatic logic [15:0] thermo(input int k);
        int lit;
        lit = (k * 16) / N;
        if (lit <= 0) return 16'h0000;
        return 16'hFFFF << (16 - lit);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input logic [SW-1:0] d, input bit with_start);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; start_btn = with_start;
        @(negedge clk);
        in_valid = 1'b0; start_btn = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 0, "R11 mem_req", mem_req, 0);
        chk(out_valid == 0, "R11 out_valid", out_valid, 0);
        chk(overrun_flag == 0, "R11 overrun", overrun_flag, 0);
        chk(led_bar == 0, "R11 led_bar", led_bar, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_idle_ignores();
        in_valid = 1'b1; in_data = 16'hDEAD;
        @(negedge clk);
        chk(mem_req == 0, "R1 idle sample no request", mem_req, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(mem_req == 0 && wr_n == 0, "R1 idle sample no write", wr_n, 0);
    endtask

    task automatic test_record_run1();
        @(negedge clk);
        start_btn = 1'b1;
        @(negedge clk);
        start_btn = 1'b0;
        for (int i = 0; i < N; i++) begin
            push(SW'(16'hA000 + i), (i == 3));
            chk(led_bar == thermo(i + 1), "R4 fill bar", led_bar, thermo(i + 1));
        end
        chk(wr_n == N, "R2 write count", wr_n, N);
        for (int i = 0; i < N; i++) begin
            chk(wr_addr[i] == AW'(i), "R2 write address / R7 start ignored", wr_addr[i], i);
            chk(wr_data[i] == SW'(16'hA000 + i), "R2 write data", wr_data[i], 16'hA000 + i);
        end
    endtask

    task automatic test_play_run1();
        for (int i = 0; i < N; i++) begin
            repeat (5) @(negedge clk);
            tick = 1'b1; start_btn = (i == 5);
            @(negedge clk);
            tick = 1'b0; start_btn = 1'b0;
            chk(out_valid == 1, "R6 out strobe", out_valid, 1);
            chk(out_data == SW'(16'hA000 + i), "R5 R6 playback order", out_data, 16'hA000 + i);
            chk(led_bar == thermo(N - (i + 1)), "R6 drain bar", led_bar, thermo(N - (i + 1)));
        end
        chk(wr_n == N, "R5 R7 no write in playback", wr_n, N);
        repeat (3) @(negedge clk);
        chk(led_bar == 0 && !mem_req, "R6 R10 idle after playback", led_bar, 0);
    endtask

    task automatic test_overrun_run2();
        int k;
        @(negedge clk);
        start_btn = 1'b1;
        @(negedge clk);
        start_btn = 1'b0;
        k = 0;
        push(16'h5000, 1'b0); exp2[k++] = 16'h5000;
        // back-to-back pair: the second arrives while the first write is outstanding
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h5001;
        @(negedge clk);
        in_data = 16'h5002;
        @(negedge clk);
        in_valid = 1'b0;
        exp2[k++] = 16'h5001;
        chk(overrun_flag == 1, "R8 overrun set", overrun_flag, 1);
        @(negedge clk);
        for (int j = 3; k < N; j++) begin
            push(SW'(16'h5000 + j), 1'b0);
            exp2[k++] = SW'(16'h5000 + j);
        end
        for (int i = 0; i < N; i++) begin
            chk(wr_addr[N + i] == AW'(i), "R8 dropped sample not stored (addr)", wr_addr[N + i], i);
            chk(wr_data[N + i] == exp2[i], "R8 dropped sample not stored (data)", wr_data[N + i], exp2[i]);
        end
    endtask

    task automatic test_repeat_run2();
        while (!(mem_req && !mem_we)) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(out_valid == 1, "R9 repeat strobe", out_valid, 1);
        chk(out_data == SW'(16'hA000 + N - 1), "R9 repeat previous", out_data, 16'hA000 + N - 1);
        chk(led_bar == thermo(N), "R9 repeat not counted", led_bar, thermo(N));
        for (int i = 0; i < N; i++) begin
            repeat (5) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk(out_data == exp2[i], "R6 playback run2", out_data, exp2[i]);
        end
        chk(led_bar == 0, "R6 all off at end", led_bar, 0);
    endtask

    task automatic test_wrapup_restart();
        // this falling edge sits in the wrap-up cycle
        start_btn = 1'b1;
        @(negedge clk);
        start_btn = 1'b0;
        chk(overrun_flag == 1, "R10 start in wrap-up ignored / R8 sticky", overrun_flag, 1);
        push(16'h7777, 1'b0);
        chk(wr_n == 2 * N, "R10 no write after ignored start", wr_n, 2 * N);
        @(negedge clk);
        start_btn = 1'b1;
        @(negedge clk);
        start_btn = 1'b0;
        chk(overrun_flag == 0, "R8 cleared by accepted start", overrun_flag, 0);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h1234;
        @(negedge clk);
        in_valid = 1'b0;
        chk(mem_req && mem_we && mem_addr == 0 && mem_wdata == 16'h1234,
            "R1 R10 restart writes address 0", mem_addr, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        summary();
    end

    initial begin
        test_reset();
        test_idle_ignores();
        test_record_run1();
        test_play_run1();
        test_overrun_run2();
        test_repeat_run2();
        test_wrapup_restart();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule